// File: doc/BRIEF.md
# One-Wire Search Triplet Sequencer

This block carries out a single branch step of a one-wire ROM search. On a start strobe it asks a bit-slot engine for two read slots. The first returns the identity bit and the second returns its complement. From that pair it decides which way the search goes, and in every case except "nobody answered" it writes the chosen direction back onto the bus with a third slot. When the step is finished it raises a one-cycle done strobe and presents a packed 3-bit result code.

The slot engine is reached through a request/acknowledge pair. The sequencer holds `slot_req_o` high, together with the bit to send on `slot_wbit_o`, until the engine answers with a one-cycle `slot_ack_i`. During that acknowledge cycle `slot_rbit_i` carries the sampled bus level. A send bit of 1 requests a write-1 slot, which is also a read slot. A send bit of 0 requests a write-0 slot. The caller supplies a preferred direction, which is used only when devices on the bus disagree. Walking all 64 ROM bit positions is left to the surrounding logic.

Top module: `ow_triplet_seq`

## Requirements
- R1: While reset is held, and after it is released, `done_o` and `slot_req_o` are 0 and `result_o` is 3'b000.
- R2: A step begins with two slots, both sent with `slot_wbit_o`=1. The bit sampled in the first slot is the identity bit and the bit sampled in the second slot is the complement bit.
- R3: When both sampled bits are 1, the result is 3'b011 and no third slot is requested.
- R4: When both sampled bits are 0, the direction equals the preferred direction captured at start. The result is 3'b100 for direction 1 and 3'b000 for direction 0.
- R5: When exactly one sampled bit is 1, the direction equals the identity bit. The result is 3'b101 when the identity bit is 1 and 3'b010 when it is 0.
- R6: In every case other than R3, a third slot is requested with `slot_wbit_o` equal to the chosen direction.
- R7: `done_o` is high for exactly one cycle, in the cycle after the acknowledge of the step's last slot. `result_o` changes only together with `done_o` and holds its value until the next step completes.
- R8: A `start_i` pulse that arrives while a step is in progress has no effect. It does not start an extra step, it does not change the preferred direction in use, and it does not add a slot.
- R9: Once raised, `slot_req_o` stays high with `slot_wbit_o` unchanged until `slot_ack_i` is seen.

The result code packs three fields. Bit 0 is the identity bit, bit 1 is the complement bit, and bit 2 is the direction taken. Bit 2 is 0 in the R3 case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin one search step (accepted only when idle) |
| pref_dir_i | input | 1 | Direction to take when both branches exist |
| done_o | output | 1 | One-cycle pulse when the step has finished |
| result_o | output | 3 | Packed code {direction, complement bit, identity bit} |
| slot_req_o | output | 1 | Slot request to the bit-slot engine |
| slot_wbit_o | output | 1 | Bit to send in the requested slot (1 = write-1/read, 0 = write-0) |
| slot_ack_i | input | 1 | One-cycle acknowledge from the slot engine |
| slot_rbit_i | input | 1 | Bus level sampled by the engine, valid with `slot_ack_i` |

## Verification
The assertions check the handshake and the output timing on every cycle. They check that the request and its send bit hold until an acknowledge arrives, that done lasts one cycle and follows an acknowledge, that no request is pending while done is high, that the result changes only together with done, and that every reported code is one of the five legal combinations. Only the bench scenarios can show the rest. Those scenarios cover whether the right sampled bit lands in the right code field, whether the preferred direction or the identity bit drives the third slot, whether the third slot is skipped on the all-ones case, and whether a start pulse during a step is dropped. They run under several slot latencies.

// File: rtl/ow_trip_pkg.sv
package ow_trip_pkg;
  localparam int CODE_W   = 3;
  localparam int POS_ID   = 0;
  localparam int POS_CMP  = 1;
  localparam int POS_DIR  = 2;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_ID  = 3'd1,
    ST_RD_CMP = 3'd2,
    ST_WR_DIR = 3'd3,
    ST_DONE   = 3'd4
  } trip_state_e;
endpackage

// File: rtl/ow_trip_rst_sync.sv
module ow_trip_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/ow_trip_decide.sv
module ow_trip_decide
  import ow_trip_pkg::*;
(
  input  logic              id_bit_i,
  input  logic              cmp_bit_i,
  input  logic              pref_i,
  output logic              err_o,
  output logic              dir_o,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    err_o = id_bit_i & cmp_bit_i;
    if (err_o)                       dir_o = 1'b0;
    else if (!id_bit_i && !cmp_bit_i) dir_o = pref_i;
    else                             dir_o = id_bit_i;
    code_o          = '0;
    code_o[POS_ID]  = id_bit_i;
    code_o[POS_CMP] = cmp_bit_i;
    code_o[POS_DIR] = dir_o;
  end
endmodule

// File: rtl/ow_trip_fsm.sv
module ow_trip_fsm
  import ow_trip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pref_dir_i,
  input  logic              slot_ack_i,
  input  logic              slot_rbit_i,
  input  logic              dec_err_i,
  input  logic              dec_dir_i,
  input  logic [CODE_W-1:0] dec_code_i,
  output logic              id_q_o,
  output logic              pref_q_o,
  output logic              done_o,
  output logic [CODE_W-1:0] result_o,
  output logic              slot_req_o,
  output logic              slot_wbit_o
);
  trip_state_e state_q, state_d;
  logic id_q, pref_q, dir_q;
  logic [CODE_W-1:0] result_q;
  logic start_en, id_en, cmp_en;

  assign start_en = (state_q == ST_IDLE) && start_i;
  assign id_en    = (state_q == ST_RD_ID) && slot_ack_i;
  assign cmp_en   = (state_q == ST_RD_CMP) && slot_ack_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i)    state_d = ST_RD_ID;
      ST_RD_ID:  if (slot_ack_i) state_d = ST_RD_CMP;
      ST_RD_CMP: if (slot_ack_i) state_d = dec_err_i ? ST_DONE : ST_WR_DIR;
      ST_WR_DIR: if (slot_ack_i) state_d = ST_DONE;
      ST_DONE:                   state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q     <= 1'b0;
      pref_q   <= 1'b0;
      dir_q    <= 1'b0;
      result_q <= '0;
    end else begin
      if (start_en) pref_q <= pref_dir_i;
      if (id_en)    id_q   <= slot_rbit_i;
      if (cmp_en) begin
        dir_q    <= dec_dir_i;
        result_q <= dec_code_i;
      end
    end
  end

  always_comb begin
    slot_req_o  = 1'b0;
    slot_wbit_o = 1'b1;
    unique case (state_q)
      ST_RD_ID, ST_RD_CMP: slot_req_o = 1'b1;
      ST_WR_DIR: begin
        slot_req_o  = 1'b1;
        slot_wbit_o = dir_q;
      end
      default: ;
    endcase
  end

  assign done_o   = (state_q == ST_DONE);
  assign result_o = (state_q == ST_DONE || state_q == ST_IDLE) ? result_q : result_hold_q;
  assign id_q_o   = id_q;
  assign pref_q_o = pref_q;

  logic [CODE_W-1:0] result_hold_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result_hold_q <= '0;
    else if (done_o) result_hold_q <= result_q;
  end
endmodule

// File: rtl/ow_triplet_seq.sv
module ow_triplet_seq
  import ow_trip_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pref_dir_i,
  output logic              done_o,
  output logic [CODE_W-1:0] result_o,
  output logic              slot_req_o,
  output logic              slot_wbit_o,
  input  logic              slot_ack_i,
  input  logic              slot_rbit_i
);
  logic rst_sync_n;
  logic id_q, pref_q, dec_err, dec_dir;
  logic [CODE_W-1:0] dec_code;

  ow_trip_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  ow_trip_decide u_dec (
    .id_bit_i  (id_q),
    .cmp_bit_i (slot_rbit_i),
    .pref_i    (pref_q),
    .err_o     (dec_err),
    .dir_o     (dec_dir),
    .code_o    (dec_code)
  );

  ow_trip_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_i),
    .pref_dir_i  (pref_dir_i),
    .slot_ack_i  (slot_ack_i),
    .slot_rbit_i (slot_rbit_i),
    .dec_err_i   (dec_err),
    .dec_dir_i   (dec_dir),
    .dec_code_i  (dec_code),
    .id_q_o      (id_q),
    .pref_q_o    (pref_q),
    .done_o      (done_o),
    .result_o    (result_o),
    .slot_req_o  (slot_req_o),
    .slot_wbit_o (slot_wbit_o)
  );
endmodule

// File: rtl/ow_triplet_seq_chk.sv
module ow_triplet_seq_chk
  import ow_trip_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              done_o,
  input logic [CODE_W-1:0] result_o,
  input logic              slot_req_o,
  input logic              slot_wbit_o,
  input logic              slot_ack_i
);
  // R9: a pending request and its bit hold until acknowledged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_o && !slot_ack_i) |=> (slot_req_o && $stable(slot_wbit_o)));

  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: done follows an acknowledge
  p_done_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(slot_ack_i));

  // R7: result only moves together with done
  p_result_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  // R3: no slot is pending while the step reports
  p_no_req_at_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !slot_req_o);

  // R3: the error code carries direction 0
  p_err_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o[1:0] == 2'b11) |-> !result_o[2]);

  // R5: a single responder forces direction to the identity bit
  p_forced_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (result_o[0] ^ result_o[1])) |-> (result_o[2] == result_o[0]));
endmodule

bind ow_triplet_seq ow_triplet_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done_o      (done_o),
  .result_o    (result_o),
  .slot_req_o  (slot_req_o),
  .slot_wbit_o (slot_wbit_o),
  .slot_ack_i  (slot_ack_i)
);

// File: tb/ow_triplet_seq_bench.sv
module ow_triplet_seq_bench;
  logic clk, rst_n, start_i, pref_dir_i;
  logic done_o, slot_req_o, slot_wbit_o, slot_ack_i, slot_rbit_i;
  logic [2:0] result_o;

  int checks, errors;

  typedef struct {
    logic [2:0] res;
    int         nslots;
    logic       dir;
  } exp_t;
  exp_t exp_q[$];

  // responder script
  logic resp_id, resp_cmp;
  int   resp_lat, resp_cnt, slot_idx, done_seen;
  logic wbits [0:7];
  logic [2:0] last_res;

  ow_triplet_seq u_ow_triplet_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pref_dir_i(pref_dir_i),
    .done_o(done_o), .result_o(result_o), .slot_req_o(slot_req_o),
    .slot_wbit_o(slot_wbit_o), .slot_ack_i(slot_ack_i), .slot_rbit_i(slot_rbit_i)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // slot engine model, driven away from the rising edge
  always @(negedge clk) begin
    if (!rst_n) begin
      slot_ack_i <= 1'b0; slot_rbit_i <= 1'b0; resp_cnt <= 0;
    end else if (slot_ack_i) begin
      slot_ack_i <= 1'b0; slot_rbit_i <= 1'b0;
    end else if (slot_req_o) begin
      if (resp_cnt >= resp_lat) begin
        slot_ack_i  <= 1'b1;
        slot_rbit_i <= (slot_idx == 0) ? resp_id : resp_cmp;
        if (slot_idx < 8) wbits[slot_idx] = slot_wbit_o;
        slot_idx    = slot_idx + 1;
        resp_cnt    <= 0;
      end else resp_cnt <= resp_cnt + 1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      done_seen++;
      if (exp_q.size() == 0) begin
        chk(0, "R8 unexpected step", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(result_o == e.res, "R3/R4/R5 result code", result_o, e.res);
        chk(slot_idx == e.nslots, "R3/R6 slot count", slot_idx, e.nslots);
        chk(wbits[0] == 1'b1 && wbits[1] == 1'b1, "R2 read slots send 1",
            {wbits[0], wbits[1]}, 3);
        if (e.nslots == 3) chk(wbits[2] == e.dir, "R6 direction slot", wbits[2], e.dir);
        last_res = e.res;
      end
    end
  end

  task automatic step(input logic id, input logic cmp, input logic pref,
                      input int lat, input bit busy_poke);
    exp_t e;
    int target;
    if (id && cmp)        begin e.res = 3'b011; e.nslots = 2; e.dir = 1'b0; end
    else if (!id && !cmp) begin e.res = {pref, 2'b00}; e.nslots = 3; e.dir = pref; end
    else                  begin e.res = {id, cmp, id}; e.nslots = 3; e.dir = id; end
    exp_q.push_back(e);
    target   = done_seen + 1;
    resp_id  = id; resp_cmp = cmp; resp_lat = lat; slot_idx = 0;
    @(negedge clk); start_i = 1'b1; pref_dir_i = pref;
    @(negedge clk); start_i = 1'b0;
    if (busy_poke) begin
      @(negedge clk); start_i = 1'b1; pref_dir_i = ~pref;  // R8 poke mid-step
      @(negedge clk); start_i = 1'b0;
    end
    while (done_seen < target) @(negedge clk);
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
    repeat (4) @(negedge clk);
    chk(result_o == e.res, "R7 result held", result_o, e.res);
    chk(slot_req_o == 1'b0 && done_seen == target, "R8 no extra activity",
        done_seen, target);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; done_seen = 0; slot_idx = 0;
    resp_id = 0; resp_cmp = 0; resp_lat = 0;
    for (int i = 0; i < 8; i++) wbits[i] = 1'b0;
    start_i = 0; pref_dir_i = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    chk(done_o == 0 && slot_req_o == 0 && result_o == 0, "R1 in reset",
        {done_o, slot_req_o, result_o}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(done_o == 0 && slot_req_o == 0 && result_o == 0, "R1 after release",
        {done_o, slot_req_o, result_o}, 0);

    step(1, 1, 1, 0, 0);  // R3 nobody answers
    step(0, 0, 1, 1, 0);  // R4 pref 1
    step(0, 0, 0, 2, 0);  // R4 pref 0
    step(1, 0, 0, 0, 0);  // R5 id 1
    step(0, 1, 1, 3, 0);  // R5 id 0
    step(0, 0, 1, 2, 1);  // R8 busy start ignored, pref kept
    step(1, 1, 0, 3, 1);  // R8 with error case, R9 long latency
    step(1, 0, 1, 1, 0);  // R6 direction 1

    chk(exp_q.size() == 0, "R7 all steps reported", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule